// File: doc/BRIEF.md
# Phase Build-Out Offset Controller

This block sits between a phase detector and the loop filter of a digital PLL. It holds a phase offset and subtracts it from the raw reference-to-output phase difference. A step at the input, or a change of reference, is then absorbed into the offset instead of being passed to the loop, so the output clock does not jump.

An offset capture starts on any of these events:

- a reference switch;
- a move of the loop from free-run, holdover or mini-holdover into locking or locked;
- a qualified transient from the phase monitor;
- turning build-out on, or releasing freeze, while the loop tracks.

During a capture the block reports a temporary holdover and feeds zero error to the loop. It averages a fixed number of phase samples and loads the average as the new offset. A freeze control holds the offset and ignores all events. Turning build-out off while the loop tracks winds the offset back to zero by a programmable step per sample. Turning it off while in free-run or holdover makes the next lock happen at zero phase.

Top module: `pbo_offset_ctrl`

## Requirements
- R1: After reset, `offset` is 0 and `temp_hold` is 0.
- R2: While `temp_hold` is 0, `phase_err` equals `phase_raw - offset` as a signed value one bit wider than `phase_raw`.
- R3: The loop-state encoding is 0 = free-run, 1 = holdover, 2 = mini-holdover, 3 = locking, 4 = locked. A change from states 0–2 into state 3 or 4, with `pbo_en`=1 and `pbo_frz`=0, raises `temp_hold` at the next clock edge. A change from 3 to 4 starts nothing.
- R4: While `temp_hold` is 1, `phase_err` is 0. The edge that registers the 2^AVG_LOG2-th `sample_stb` loads `offset` with floor(sum of the strobed samples / 2^AVG_LOG2) and clears `temp_hold`.
- R5: A `ref_switch` pulse with `pbo_en`=1 and `pbo_frz`=0 starts a capture (R4).
- R6: A `transient_trig` pulse with `pbo_en`=1 and `pbo_frz`=0 starts a capture.
- R7: While `pbo_frz`=1 and `pbo_en`=1:
  - `ref_switch`, `transient_trig` and `sample_stb` leave `offset` unchanged;
  - no capture starts.
- R8: While the loop is in state 3 or 4, a capture starts when `pbo_en` rises with `pbo_frz`=0, or when `pbo_frz` falls with `pbo_en`=1. A rise of `pbo_en` in states 0–2 starts nothing.
- R9: With `pbo_en`=0 in state 3 or 4, each `sample_stb` moves `offset` toward zero by `unwind_step`. The offset stops at zero and does not cross it.
- R10: With `pbo_en`=0, either `ref_switch` or a change from states 0–2 into 3/4 sets `offset` to 0 at the next edge.
- R11: Clearing `pbo_en` or setting `pbo_frz` during a capture ends it at the next edge. `offset` keeps its previous value and `temp_hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe marking a new phase sample |
| phase_raw | input | PW | Raw signed reference-to-output phase difference |
| loop_st | input | 3 | Loop state (encoding in R3) |
| ref_switch | input | 1 | One-cycle pulse on a reference change |
| transient_trig | input | 1 | One-cycle pulse for a qualified input transient |
| pbo_en | input | 1 | Build-out enable |
| pbo_frz | input | 1 | Build-out freeze |
| unwind_step | input | PW | Unsigned offset decrement per strobe while disabled |
| phase_err | output | PW+1 | Corrected signed phase error to the loop filter |
| offset | output | PW | Current signed build-out offset |
| temp_hold | output | 1 | Temporary holdover during a capture |

## Verification
The bench builds the block with PW = 12 and AVG_LOG2 = 2, so a capture takes four strobes. Hand-computed averages reach both exact results and floor rounding of a negative sum (-7/4 gives -2). The 12-bit width gives room for offsets of several hundred units in both signs. A step of 3 against an offset of 8 brings the saturating end of the unwind within three strobes. The sequence also takes the loop through mini-holdover, holdover, locking and locked, so it can show which state changes start a capture or clear the offset.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

    typedef enum logic [2:0] {
        LS_FREERUN  = 3'd0,
        LS_HOLDOVER = 3'd1,
        LS_MINIHOLD = 3'd2,
        LS_LOCKING  = 3'd3,
        LS_LOCKED   = 3'd4
    } loop_st_e;

    // true when the loop follows a reference (locking or locked)
    function automatic logic is_tracking(input logic [2:0] st);
        return (st == LS_LOCKING) || (st == LS_LOCKED);
    endfunction

endpackage

// File: rtl/pbo_event_detect.sv
module pbo_event_detect
    import pbo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] loop_st,
    input  logic       ref_switch,
    input  logic       transient,
    input  logic       en,
    input  logic       frz,
    input  logic       busy,
    output logic       start,
    output logic       clear,
    output logic       tracking
);

    typedef struct packed {
        logic [2:0] st;
        logic       en;
        logic       frz;
    } hist_t;

    hist_t h_d, h_q;
    logic  exit_hold, en_rise, frz_fall;

    always_comb begin
        h_d.st    = loop_st;
        h_d.en    = en;
        h_d.frz   = frz;
        tracking  = is_tracking(loop_st);
        exit_hold = !is_tracking(h_q.st) && tracking;
        en_rise   = en && !h_q.en;
        frz_fall  = !frz && h_q.frz;
        start     = en && !frz && !busy &&
                    (ref_switch || transient || exit_hold ||
                     (tracking && (en_rise || frz_fall)));
        clear     = !en && (ref_switch || exit_hold);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q.st  <= LS_FREERUN;
            h_q.en  <= 1'b0;
            h_q.frz <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

endmodule

// File: rtl/pbo_capture.sv
module pbo_capture #(
    parameter int PW       = 16,
    parameter int AVG_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic                 stb,
    input  logic signed [PW-1:0] sample,
    output logic                 busy,
    output logic                 done,
    output logic signed [PW-1:0] avg
);

    localparam int NSAMP = 1 << AVG_LOG2;
    localparam int AW    = PW + AVG_LOG2;
    localparam int CW    = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

    typedef struct packed {
        logic                 busy;
        logic [CW-1:0]        cnt;
        logic signed [AW-1:0] acc;
    } cap_t;

    cap_t s_d, s_q;
    logic signed [AW-1:0] samp_x, sum;
    logic                 last;

    always_comb begin
        samp_x = AW'(sample);
        sum    = s_q.acc + samp_x;
        last   = (s_q.cnt == CW'(NSAMP - 1));
        done   = s_q.busy && !abort && stb && last;
        avg    = PW'(sum >>> AVG_LOG2);
        busy   = s_q.busy;
        s_d    = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.acc  = '0;
        end else if (s_q.busy && stb) begin
            s_d.acc = sum;
            s_d.cnt = s_q.cnt + 1'b1;
            if (last) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pbo_unwind.sv
module pbo_unwind #(
    parameter int PW = 16
) (
    input  logic signed [PW-1:0] cur,
    input  logic        [PW-1:0] step,
    output logic signed [PW-1:0] nxt
);

    logic signed [PW:0] cur_x, stp_x, res, mag;

    always_comb begin
        cur_x = (PW+1)'(cur);
        stp_x = $signed({1'b0, step});
        mag   = cur_x[PW] ? -cur_x : cur_x;
        res   = cur_x[PW] ? (cur_x + stp_x) : (cur_x - stp_x);
        if ($unsigned(mag) <= $unsigned(stp_x)) nxt = '0;
        else                                    nxt = PW'(res);
    end

endmodule

// File: rtl/pbo_offset_ctrl.sv
module pbo_offset_ctrl #(
    parameter int PW       = 16,
    parameter int AVG_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic signed [PW-1:0] phase_raw,
    input  logic [2:0]           loop_st,
    input  logic                 ref_switch,
    input  logic                 transient_trig,
    input  logic                 pbo_en,
    input  logic                 pbo_frz,
    input  logic [PW-1:0]        unwind_step,
    output logic signed [PW:0]   phase_err,
    output logic signed [PW-1:0] offset,
    output logic                 temp_hold
);

    typedef struct packed {
        logic signed [PW-1:0] off;
    } ofs_t;

    ofs_t o_d, o_q;
    logic start, clear, tracking, busy, done, abort;
    logic signed [PW-1:0] avg, unwound;

    pbo_event_detect u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_st    (loop_st),
        .ref_switch (ref_switch),
        .transient  (transient_trig),
        .en         (pbo_en),
        .frz        (pbo_frz),
        .busy       (busy),
        .start      (start),
        .clear      (clear),
        .tracking   (tracking)
    );

    pbo_capture #(.PW(PW), .AVG_LOG2(AVG_LOG2)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (abort),
        .stb    (sample_stb),
        .sample (phase_raw),
        .busy   (busy),
        .done   (done),
        .avg    (avg)
    );

    pbo_unwind #(.PW(PW)) u_unw (
        .cur  (o_q.off),
        .step (unwind_step),
        .nxt  (unwound)
    );

    always_comb begin
        abort = busy && (!pbo_en || pbo_frz);
        o_d   = o_q;
        if (done)                                  o_d.off = avg;
        else if (clear)                            o_d.off = '0;
        else if (!pbo_en && tracking && sample_stb) o_d.off = unwound;
        offset    = o_q.off;
        temp_hold = busy;
        phase_err = busy ? '0 : ((PW+1)'(phase_raw) - (PW+1)'(o_q.off));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

endmodule

// File: rtl/pbo_offset_ctrl_chk.sv
module pbo_offset_ctrl_chk #(
    parameter int PW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_switch,
    input logic                 pbo_en,
    input logic                 pbo_frz,
    input logic                 temp_hold,
    input logic signed [PW-1:0] offset
);

    function automatic logic [PW:0] mag(input logic signed [PW-1:0] v);
        logic signed [PW:0] vx;
        vx = (PW+1)'(v);
        return vx[PW] ? $unsigned(-vx) : $unsigned(vx);
    endfunction

    // R4: offset does not move while the capture runs
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_hold && $past(temp_hold)) |-> $stable(offset));

    // R7: frozen and enabled keeps the offset
    p_frz_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pbo_frz) && $past(pbo_en)) |-> $stable(offset));

    // R9: while disabled the offset magnitude never grows
    p_unwind_shrink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pbo_en) |-> (mag(offset) <= mag($past(offset))));

    // R9: unwinding never crosses zero
    p_no_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pbo_en) && $past(offset) != 0) |->
        (offset == 0 || offset[PW-1] == $past(offset[PW-1])));

    // R5: enabled reference switch opens a temporary holdover
    p_switch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_switch && pbo_en && !pbo_frz && !temp_hold) |-> temp_hold);

    // R10: disabled reference switch zeroes the offset
    p_switch_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_switch && !pbo_en) |-> (offset == 0));

endmodule

bind pbo_offset_ctrl pbo_offset_ctrl_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_switch (ref_switch),
    .pbo_en     (pbo_en),
    .pbo_frz    (pbo_frz),
    .temp_hold  (temp_hold),
    .offset     (offset)
);

// File: tb/pbo_offset_ctrl_tb.sv
module pbo_offset_ctrl_tb;

    localparam int PW = 12;
    localparam int AL = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 sample_stb, ref_switch, transient_trig, pbo_en, pbo_frz;
    logic signed [PW-1:0] phase_raw;
    logic [2:0]           loop_st;
    logic [PW-1:0]        unwind_step;
    logic signed [PW:0]   phase_err;
    logic signed [PW-1:0] offset;
    logic                 temp_hold;

    typedef struct {
        int    off;
        bit    hold;
        int    err;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    pbo_offset_ctrl #(.PW(PW), .AVG_LOG2(AL)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_stb     (sample_stb),
        .phase_raw      (phase_raw),
        .loop_st        (loop_st),
        .ref_switch     (ref_switch),
        .transient_trig (transient_trig),
        .pbo_en         (pbo_en),
        .pbo_frz        (pbo_frz),
        .unwind_step    (unwind_step),
        .phase_err      (phase_err),
        .offset         (offset),
        .temp_hold      (temp_hold)
    );

    // driver: apply one cycle of stimulus at the falling edge
    task automatic drv(input int st, input bit sw, input bit tr, input bit en,
                       input bit frz, input bit stb, input int raw);
        @(negedge clk);
        loop_st        = 3'(st);
        ref_switch     = sw;
        transient_trig = tr;
        pbo_en         = en;
        pbo_frz        = frz;
        sample_stb     = stb;
        phase_raw      = PW'(raw);
    endtask

    // expectation for the outputs just after the coming rising edge
    task automatic expect_(input int off, input bit hold, input int err, input string tag);
        exp_t e;
        e.off = off; e.hold = hold; e.err = err; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare outputs shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                int   ao, ae;
                e  = q.pop_front();
                ao = int'(offset);
                ae = int'(phase_err);
                n_chk++;
                if (ao != e.off || temp_hold != e.hold || ae != e.err) begin
                    n_bad++;
                    $display("FAIL %s: offset=%0d hold=%0d err=%0d expected offset=%0d hold=%0d err=%0d",
                             e.tag, ao, temp_hold, ae, e.off, e.hold, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    localparam int FR = 0, HO = 1, MH = 2, LK = 3, LD = 4;

    initial begin
        rst_n = 1'b0; loop_st = 3'(FR); ref_switch = 0; transient_trig = 0;
        pbo_en = 1; pbo_frz = 0; sample_stb = 0; phase_raw = '0; unwind_step = PW'(3);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state, R2 pass-through
        drv(FR, 0, 0, 1, 0, 0, 100); expect_(0, 0, 100, "R1");
        // R3 leaving free-run starts capture
        drv(LD, 0, 0, 1, 0, 0, 100); expect_(0, 1, 0, "R3");
        drv(LD, 0, 0, 1, 0, 1, 40);  expect_(0, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, 40);  expect_(0, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, 44);  expect_(0, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, 44);  expect_(42, 0, 2, "R4");
        drv(LD, 0, 0, 1, 0, 0, -10); expect_(42, 0, -52, "R2");
        // R6 transient, negative floor average (R4)
        drv(LD, 0, 1, 1, 0, 0, 0);   expect_(42, 1, 0, "R6");
        drv(LD, 0, 0, 1, 0, 1, -1);  expect_(42, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, -2);  expect_(42, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, -2);  expect_(42, 1, 0, "R4");
        drv(LD, 0, 0, 1, 0, 1, -2);  expect_(-2, 0, 0, "R4");
        drv(LD, 0, 0, 1, 0, 0, 10);  expect_(-2, 0, 12, "R4");
        // R5 reference switch
        drv(LD, 1, 0, 1, 0, 0, 0);   expect_(-2, 1, 0, "R5");
        for (int i = 0; i < 3; i++) begin
            drv(LD, 0, 0, 1, 0, 1, 200); expect_(-2, 1, 0, "R5");
        end
        drv(LD, 0, 0, 1, 0, 1, 200); expect_(200, 0, 0, "R5");
        // R7 freeze ignores events and strobes
        drv(LD, 1, 0, 1, 1, 0, 5);   expect_(200, 0, -195, "R7");
        drv(LD, 0, 1, 1, 1, 0, 5);   expect_(200, 0, -195, "R7");
        drv(LD, 0, 0, 1, 1, 1, 5);   expect_(200, 0, -195, "R7");
        // R8 releasing freeze while locked
        drv(LD, 0, 0, 1, 0, 0, 8);   expect_(200, 1, 0, "R8");
        for (int i = 0; i < 3; i++) begin
            drv(LD, 0, 0, 1, 0, 1, 8); expect_(200, 1, 0, "R8");
        end
        drv(LD, 0, 0, 1, 0, 1, 8);   expect_(8, 0, 0, "R8");
        // R11 abort by freeze
        drv(LD, 0, 1, 1, 0, 0, 0);   expect_(8, 1, 0, "R6");
        drv(LD, 0, 0, 1, 0, 1, 100); expect_(8, 1, 0, "R11");
        drv(LD, 0, 0, 1, 1, 0, 100); expect_(8, 0, 92, "R11");
        // R9 unwind with saturation
        drv(LD, 0, 0, 0, 1, 1, 0);   expect_(5, 0, -5, "R9");
        drv(LD, 0, 0, 0, 1, 1, 0);   expect_(2, 0, -2, "R9");
        drv(LD, 0, 0, 0, 1, 1, 0);   expect_(0, 0, 0, "R9");
        drv(LD, 0, 0, 0, 1, 1, 0);   expect_(0, 0, 0, "R9");
        // R8 enable rising while locked
        drv(LD, 0, 0, 0, 0, 0, 0);   expect_(0, 0, 0, "R8");
        drv(LD, 0, 0, 1, 0, 0, 30);  expect_(0, 1, 0, "R8");
        for (int i = 0; i < 3; i++) begin
            drv(LD, 0, 0, 1, 0, 1, 30); expect_(0, 1, 0, "R8");
        end
        drv(LD, 0, 0, 1, 0, 1, 30);  expect_(30, 0, 0, "R8");
        // R11 abort by disable
        drv(LD, 0, 1, 1, 0, 0, 0);   expect_(30, 1, 0, "R6");
        drv(LD, 0, 0, 1, 0, 1, 50);  expect_(30, 1, 0, "R11");
        drv(LD, 0, 0, 0, 0, 0, 50);  expect_(30, 0, 20, "R11");
        // R10 disabled switch clears offset
        drv(LD, 1, 0, 0, 0, 0, 50);  expect_(0, 0, 50, "R10");
        // R8 enable rise outside tracking starts nothing; R3 mini-holdover exit
        drv(MH, 0, 0, 0, 0, 0, 0);   expect_(0, 0, 0, "R8");
        drv(MH, 0, 0, 1, 0, 0, 0);   expect_(0, 0, 0, "R8");
        drv(LK, 0, 0, 1, 0, 0, 0);   expect_(0, 1, 0, "R3");
        for (int i = 0; i < 3; i++) begin
            drv(LK, 0, 0, 1, 0, 1, 12); expect_(0, 1, 0, "R3");
        end
        drv(LK, 0, 0, 1, 0, 1, 12);  expect_(12, 0, 0, "R4");
        drv(LD, 0, 0, 1, 0, 0, 12);  expect_(12, 0, 0, "R3");
        // R10 disabled exit from holdover clears offset
        drv(HO, 0, 0, 0, 0, 0, 12);  expect_(12, 0, 0, "R10");
        drv(LD, 0, 0, 0, 0, 0, 12);  expect_(0, 0, 12, "R10");

        drv(LD, 0, 0, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #3;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule